// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tags and Line Status

This block buffers received serial characters in a small first-in first-out store. Every entry carries its data byte together with three error tags raised by the receiver: a parity mismatch, a bad stop bit and a break. The tags travel with their character through the store. The status word reports the tags of whichever character is at the head right now, not the character most recently received.

An 8-bit line status word is kept in a register. It reports whether data is waiting, whether a character was lost to a full store, and the head character's three error tags. It also carries a summary bit that stays set while any tagged character may still be in the store. Two transmit-side bits are formed from a pair of inputs that say whether the transmit holding register and the transmit shift register are empty. A one-cycle read strobe on the status word clears the sticky indications. The consumer pops characters from the head, and the head byte is visible on the data output at all times.

Top module: `rxf_linestat`

## Requirements
- R1: After reset the status word reads 0x60: bits 5 and 6 are 1 and every other bit is 0. The store is empty.
- R2: Characters leave the store in the order they were pushed, and the head byte is always on `rx_data_o`. Status bit 0 is 1 exactly when the store holds at least one character. The bit is registered, so it reflects the store one cycle after a push or pop.
- R3: A push while the store already holds DEPTH characters, with no pop in the same cycle, is dropped and sets status bit 1 (overrun). A status read clears bit 1. A push and a pop together on a full store are both accepted and do not set bit 1.
- R4: Status bits 2, 3 and 4 show the parity, stop-bit and break tags of the head character, in that order. Whenever the head changes to a new character, the bits load that character's tags. They are 0 while the store is empty.
- R5: A status read clears bits 1 to 4 on the next cycle, and they stay 0 until a new overrun happens or the head changes.
- R6: Status bit 7 sets in the cycle after a character with any of its three tags set is accepted into the store.
- R7: A status read clears bit 7 only if no tagged character remains in the store after that cycle's push and pop. Otherwise bit 7 stays 1. Popping the last tagged character does not clear bit 7 by itself.
- R8: When a status read coincides with an event that sets a bit, the set wins. The events are an overrun, a head change to a tagged character, or the acceptance of a tagged character.
- R9: Status bit 5 follows the holding-empty input. Bit 6 is 1 only when both the holding-empty and shift-empty inputs are 1. Both bits are registered with one cycle of latency.
- R10: The store holds exactly DEPTH (default 16) characters before an overrun occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push_i | input | 1 | Push one received character |
| rx_data_i | input | DW | Received byte |
| rx_perr_i | input | 1 | Parity tag of the pushed character |
| rx_ferr_i | input | 1 | Stop-bit tag of the pushed character |
| rx_brk_i | input | 1 | Break tag of the pushed character |
| rx_pop_i | input | 1 | Remove the head character |
| rx_data_o | output | DW | Byte at the head of the store |
| lsr_rd_i | input | 1 | Status-word read strobe (clears sticky bits) |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| tsr_empty_i | input | 1 | Transmit shift register is empty |
| lsr_o | output | 8 | Line status word |

## Verification
The bench pushes one character at a time for each of the eight tag combinations. This shows that each tag lands on its own status bit and that a read clears the head tags while bit 7 holds for the still-stored character. A full fill with a tag pattern that repeats every eight entries, followed by a complete drain, checks that tags follow their own character through the store and that nothing is lost before overrun. A short sequence with a tagged character followed by a clean one separates the summary bit's "no tagged entry left" rule from "store empty". Reads that coincide with a tagged push or an overrun show that the set wins. A sweep of all four transmit input pairs covers bits 5 and 6.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // error tags in status-word bit order (bit 4 .. bit 2)
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_err_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 11,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_entry,
  input  logic          rd_en,
  output logic [EW-1:0] head_o,
  output logic [2:0]    next_err_o,
  output logic [CW-1:0] count_o
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] next_entry;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage array without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_inc(wr_ptr);
      if (rd_en) rd_ptr <= ptr_inc(rd_ptr);
      count_o <= count_o + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign head_o     = mem[rd_ptr];
  assign next_entry = mem[ptr_inc(rd_ptr)];
  assign next_err_o = next_entry[EW-1:EW-3];
endmodule

// File: rtl/rxf_errcnt.sv
module rxf_errcnt #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic          left_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_next;

  assign cnt_next = cnt_o + CW'(inc_i) - CW'(dec_i);
  assign left_o   = (cnt_next != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_next;
  end
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_i,
  input  logic       ready_i,
  input  logic       ovr_i,
  input  logic       head_chg_i,
  input  rx_err_t    head_err_i,
  input  logic       err_push_i,
  input  logic       err_left_i,
  input  logic       thr_i,
  input  logic       tsr_i,
  output logic [7:0] lsr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lsr_o <= 8'h60;
    end else begin
      lsr_o[0] <= ready_i;
      lsr_o[1] <= ovr_i | (lsr_o[1] & ~rd_i);
      if (head_chg_i)  lsr_o[4:2] <= head_err_i;
      else if (rd_i)   lsr_o[4:2] <= '0;
      lsr_o[5] <= thr_i;
      lsr_o[6] <= thr_i & tsr_i;
      lsr_o[7] <= err_push_i | (lsr_o[7] & (~rd_i | err_left_i));
    end
  end
endmodule

// File: rtl/rxf_linestat.sv
module rxf_linestat
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int EW = DW + 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_perr_i,
  input  logic          rx_ferr_i,
  input  logic          rx_brk_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  input  logic          lsr_rd_i,
  input  logic          thr_empty_i,
  input  logic          tsr_empty_i,
  output logic [7:0]    lsr_o
);
  logic [CW-1:0] count;
  logic [CW-1:0] err_cnt;
  logic [EW-1:0] head;
  logic [2:0]    next_err;
  logic          full, empty, do_push, do_pop, ovr_evt, head_chg, err_left;
  rx_err_t       in_err, head_err, new_head_err;

  assign in_err   = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i};
  assign head_err = rx_err_t'(head[EW-1:DW]);
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign do_pop   = rx_pop_i & ~empty;
  assign do_push  = rx_push_i & (~full | do_pop);
  assign ovr_evt  = rx_push_i & full & ~do_pop;
  assign head_chg = do_pop | (empty & do_push);

  // tags of whichever character sits at the head after this cycle
  always_comb begin
    if (do_pop) begin
      if (count > CW'(1))  new_head_err = rx_err_t'(next_err);
      else if (do_push)    new_head_err = in_err;
      else                 new_head_err = '0;
    end else begin
      new_head_err = in_err;
    end
  end

  rxf_store #(.DEPTH(DEPTH), .EW(EW)) store_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (do_push),
    .wr_entry  ({in_err, rx_data_i}),
    .rd_en     (do_pop),
    .head_o    (head),
    .next_err_o(next_err),
    .count_o   (count)
  );

  rxf_errcnt #(.DEPTH(DEPTH)) errcnt_i (
    .clk   (clk),
    .rst   (rst),
    .inc_i (do_push & (|in_err)),
    .dec_i (do_pop & (|head_err)),
    .left_o(err_left),
    .cnt_o (err_cnt)
  );

  rxf_status status_i (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (lsr_rd_i),
    .ready_i   (count + CW'(do_push) - CW'(do_pop) != '0),
    .ovr_i     (ovr_evt),
    .head_chg_i(head_chg),
    .head_err_i(new_head_err),
    .err_push_i(do_push & (|in_err)),
    .err_left_i(err_left),
    .thr_i     (thr_empty_i),
    .tsr_i     (tsr_empty_i),
    .lsr_o     (lsr_o)
  );

  assign rx_data_o = head[DW-1:0];
endmodule

// File: rtl/rxf_linestat_chk.sv
module rxf_linestat_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic          rx_perr_i,
  input logic          rx_ferr_i,
  input logic          rx_brk_i,
  input logic          lsr_rd_i,
  input logic          thr_empty_i,
  input logic          tsr_empty_i,
  input logic [7:0]    lsr_o,
  input logic [CW-1:0] count,
  input logic [CW-1:0] err_cnt
);
  // R2: ready bit mirrors store occupancy
  a_r2_ready: assert property (@(posedge clk) disable iff (rst)
    lsr_o[0] == (count != '0));
  // R10: occupancy never exceeds the depth
  a_r10_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R3: a push into a full store without pop flags overrun
  a_r3_overrun: assert property (@(posedge clk) disable iff (rst)
    (rx_push_i && count == CW'(DEPTH) && !rx_pop_i) |=> lsr_o[1]);
  // R4: no head tags while the store is empty
  a_r4_empty_tags: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (lsr_o[4:2] == 3'b000));
  // R5: a quiet status read clears bits 1..4
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd_i && !rx_push_i && !rx_pop_i) |=> (lsr_o[4:1] == 4'b0000));
  // R6: accepted tagged character sets the summary bit
  a_r6_errpush: assert property (@(posedge clk) disable iff (rst)
    (rx_push_i && (count < CW'(DEPTH) || rx_pop_i) &&
     (rx_perr_i || rx_ferr_i || rx_brk_i)) |=> lsr_o[7]);
  // R7: summary bit clear implies no tagged entry stored
  a_r7_no_hidden: assert property (@(posedge clk) disable iff (rst)
    !lsr_o[7] |-> (err_cnt == '0));
  // R9: transmit bits
  a_r9_temt: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lsr_o[6] == ($past(thr_empty_i) && $past(tsr_empty_i))));
  a_r9_thre: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lsr_o[5] == $past(thr_empty_i)));
endmodule

bind rxf_linestat rxf_linestat_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rx_push_i  (rx_push_i),
  .rx_pop_i   (rx_pop_i),
  .rx_perr_i  (rx_perr_i),
  .rx_ferr_i  (rx_ferr_i),
  .rx_brk_i   (rx_brk_i),
  .lsr_rd_i   (lsr_rd_i),
  .thr_empty_i(thr_empty_i),
  .tsr_empty_i(tsr_empty_i),
  .lsr_o      (lsr_o),
  .count      (count),
  .err_cnt    (err_cnt)
);

// File: tb/rxf_linestat_tb.sv
module rxf_linestat_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push = 1'b0, pop = 1'b0, rd = 1'b0;
  logic [7:0] din = '0;
  logic [2:0] fin = '0;
  logic       thr = 1'b1, tsr = 1'b1;
  logic [7:0] dout, lsr;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  rxf_linestat #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst(rst),
    .rx_push_i(push), .rx_data_i(din),
    .rx_perr_i(fin[0]), .rx_ferr_i(fin[1]), .rx_brk_i(fin[2]),
    .rx_pop_i(pop), .rx_data_o(dout), .lsr_rd_i(rd),
    .thr_empty_i(thr), .tsr_empty_i(tsr), .lsr_o(lsr)
  );

  function automatic logic [7:0] dat(input int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [2:0] flg(input int i);
    return 3'(i % 8);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // one clock cycle with the given strobes; outputs are sampled after it
  task automatic cyc(input logic p, input logic [7:0] d, input logic [2:0] f,
                     input logic q, input logic s);
    push = p; din = d; fin = f; pop = q; rd = s;
    @(posedge clk); #1;
    push = 0; pop = 0; rd = 0; fin = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 reset word", lsr, 8'h60);

    // R4 R5 R6 R7: single character with every tag combination
    for (int f = 0; f < 8; f++) begin
      cyc(1, 8'hA0 + 8'(f), 3'(f), 0, 0);
      chk("R4 head tags", {5'b0, lsr[4:2]}, {5'b0, 3'(f)});
      chk("R6 summary on push", {7'b0, lsr[7]}, {7'b0, (f != 0)});
      chk("R2 ready/data", {lsr[0], dout[6:0]}, {1'b1, 7'(8'hA0 + 8'(f))});
      cyc(0, 0, 0, 0, 1);
      chk("R5 read clears tags", {4'b0, lsr[4:1]}, 8'h00);
      chk("R7 summary kept while stored", {7'b0, lsr[7]}, {7'b0, (f != 0)});
      cyc(0, 0, 0, 1, 0);
      chk("R2 empty after pop", {6'b0, lsr[7], lsr[0]}, {6'b0, (f != 0), 1'b0});
      cyc(0, 0, 0, 0, 1);
      chk("R7 summary cleared when none left", {7'b0, lsr[7]}, 8'h00);
    end

    // R10 R3: fill to depth, then one more
    for (int i = 0; i < DEPTH; i++) cyc(1, dat(i), flg(i), 0, 0);
    chk("R10 full without overrun", {6'b0, lsr[1], lsr[0]}, 8'h01);
    cyc(1, 8'hEE, 3'b111, 0, 0);
    chk("R3 overrun set", {7'b0, lsr[1]}, 8'h01);
    cyc(0, 0, 0, 0, 1);
    chk("R3 overrun cleared by read", {7'b0, lsr[1]}, 8'h00);
    chk("R7 summary kept with tagged entries", {7'b0, lsr[7]}, 8'h01);
    // R2 R4: drain in order, tags follow their character
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 order", dout, dat(i));
      cyc(0, 0, 0, 1, 0);
      chk("R4 tags of new head", {5'b0, lsr[4:2]},
          {5'b0, (i < DEPTH - 1) ? flg(i + 1) : 3'b000});
    end
    chk("R7 summary survives last pop", {6'b0, lsr[7], lsr[0]}, 8'h02);
    cyc(0, 0, 0, 0, 1);
    chk("R7 read after drain", {7'b0, lsr[7]}, 8'h00);

    // R7: tagged then clean; summary clears with clean entry still stored
    cyc(1, 8'h11, 3'b001, 0, 0);
    cyc(1, 8'h22, 3'b000, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R7 summary before read", {5'b0, lsr[7], lsr[2], lsr[0]}, 8'h05);
    cyc(0, 0, 0, 0, 1);
    chk("R7 clears with clean head", {6'b0, lsr[7], lsr[0]}, 8'h01);
    chk("R2 clean head data", dout, 8'h22);
    cyc(0, 0, 0, 1, 0);

    // R8: read together with a tagged push into an empty store
    cyc(1, 8'h33, 3'b100, 0, 1);
    chk("R8 push beats read", {5'b0, lsr[7], lsr[4], lsr[0]}, 8'h07);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R8 cleanup", lsr & 8'h9F, 8'h00);

    // R8 R3: overrun together with read; then push+pop while full
    for (int i = 0; i < DEPTH; i++) cyc(1, dat(i), 3'b000, 0, 0);
    cyc(1, 8'hEE, 3'b000, 0, 1);
    chk("R8 overrun beats read", {7'b0, lsr[1]}, 8'h01);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 8'h77, 3'b000, 1, 0);
    chk("R3 push+pop when full", {6'b0, lsr[1], lsr[0]}, 8'h01);
    chk("R3 head advanced", dout, dat(1));
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 0);
    chk("R2 drained", {7'b0, lsr[0]}, 8'h00);

    // R9: transmit inputs
    for (int k = 0; k < 4; k++) begin
      thr = k[0]; tsr = k[1];
      @(posedge clk); #1;
      chk("R9 tx bits", {6'b0, lsr[6], lsr[5]}, {6'b0, k[0] & k[1], k[0]});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule